// File: doc/BRIEF.md
# Bridge Header Presentation Shim for a Root Port

This block sits between the configuration-access engine of a root port and that port's native register file. The native file is laid out as an endpoint-style (Type 0) header, but software expects a bridge-style (Type 1) header from the root port. The shim fixes this on the fly. It serves the bridge-specific and BAR dwords of the header from a small local shadow store and patches a few fields on the way out. It also turns byte and halfword writes into whole-dword read-modify-write cycles.

Each access takes two cycles. In the request cycle the old dword is read from the shadow store or, through a combinational read port, from the native file. In the second cycle the shim pulses `done`, returns the read data right-aligned, and commits a write. The shim also snoops the secondary bus number and a retry-visibility enable, and drives both to neighbouring blocks.

Top module: `cfg_bridge_hdr_shim`

## Requirements
- R1: Dword indices 4 to 12 (byte offsets 0x10 to 0x33) and index 14 (0x38 to 0x3B) are held in a local shadow store of ten dwords and never appear on the native port. Every other offset is read through the native port, with `nat_rd_en` high in the request cycle. On a write, `nat_wr_en` is high with the merged dword in the second cycle.
- R2: A write of any width to the dwords at 0x10, 0x14 or 0x38 stores zero, so those dwords later read back as zero.
- R3: A read of the dword at 0x0C returns bits 22:16 as 0x01. All of its other bits, bit 23 included, come from the native file.
- R4: Bit 4 of the dword at 0xDC is a local retry-visibility flag, which resets to 0. Any write to that dword loads the flag from bit 4 of the merged dword. Reads of the dword return bit 4 ORed with the flag, and `retry_vis_en` outputs the flag.
- R5: Reads of the dword at 0xDC always return bit 16 as 1.
- R6: After reset, the shadow dword at 0x1C reads 0x00000101, the shadow dword at 0x24 reads 0x00010001, and all other shadow dwords read zero.
- R7: `req_size` encodes 0 as byte, 1 as halfword, and 2 or 3 as word. A byte write replaces the byte selected by offset bits 1:0. A halfword write replaces the half selected by offset bit 1. A word write replaces the whole dword. All other bytes keep their old value.
- R8: A read returns the byte or halfword selected in the same way as in R7, right-aligned and zero-extended. A word read returns the whole dword.
- R9: `sec_bus` resets to 0. It loads bits 15:8 of the merged dword on a byte write at offset 0x19, on a halfword write at 0x18 or 0x19, or on a word write to the dword at 0x18. Any other write leaves it unchanged.
- R10: A request accepted while the shim is idle raises `done` for exactly one cycle, in the cycle after acceptance. A `req_valid` that is high during the `done` cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, accepted when the shim is idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_offset | input | OFFS_W | Byte offset into the header space |
| req_wdata | input | 32 | Write data, right-aligned |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read result, valid while `done` is high |
| nat_rd_en | output | 1 | Native file read strobe (request cycle) |
| nat_wr_en | output | 1 | Native file write strobe (second cycle) |
| nat_addr | output | OFFS_W | Dword-aligned native file address |
| nat_wdata | output | 32 | Merged dword for the native file |
| nat_rdata | input | 32 | Native file read data, same cycle as the address |
| sec_bus | output | 8 | Snooped secondary bus number |
| retry_vis_en | output | 1 | Retry-visibility enable flag |

## Verification
The bench aims at the lane arithmetic. A merge that used the wrong lane would corrupt neighbouring bytes of native and shadow dwords, and the bench reads those dwords back at every width. It probes the edges of the shadow window (0x0C, 0x34 and 0x3C go native; 0x30 and 0x38 stay local), so an off-by-one range decode shows up as native traffic or stale data. It covers each write form that should or should not load the secondary bus number, so a shim that captured on a plain byte write at 0x18 would move `sec_bus` wrongly. It also raises a stray request during the completion cycle, which a shim that accepted it would turn into a second `done` and a corrupted shadow dword.

// File: rtl/cfgshim_pkg.sv
package cfgshim_pkg;

   typedef enum logic [1:0] {
      ACC_BYTE = 2'd0,
      ACC_HALF = 2'd1,
      ACC_WORD = 2'd2,
      ACC_WIDE = 2'd3
   } acc_size_e;

   localparam logic [31:0] IO_RANGE32_RST  = 32'h0000_0101;
   localparam logic [31:0] PF_RANGE64_RST  = 32'h0001_0001;
   localparam int          HDR_TYPE_LSB    = 16;
   localparam logic [6:0]  HDR_TYPE_BRIDGE = 7'h01;

endpackage

// File: rtl/cfgshim_lanes.sv
module cfgshim_lanes
   import cfgshim_pkg::*;
(
   input  logic [31:0] base_dw,
   input  logic [31:0] new_data,
   input  logic [1:0]  size,
   input  logic [1:0]  lane,
   output logic [31:0] merged_dw,
   input  logic [31:0] rd_dw,
   output logic [31:0] rd_val
);

   for (genvar b = 0; b < 4; b++) begin : g_byte
      localparam logic [1:0] BI = 2'(b);
      logic       be;
      logic [7:0] src;
      always_comb begin
         case (acc_size_e'(size))
            ACC_BYTE: begin
               be  = (lane == BI);
               src = new_data[7:0];
            end
            ACC_HALF: begin
               be  = (lane[1] == BI[1]);
               src = new_data[8*(b%2) +: 8];
            end
            default: begin
               be  = 1'b1;
               src = new_data[8*b +: 8];
            end
         endcase
      end
      assign merged_dw[8*b +: 8] = be ? src : base_dw[8*b +: 8];
   end

   always_comb begin
      case (acc_size_e'(size))
         ACC_BYTE: rd_val = {24'h0, rd_dw[{lane, 3'b000} +: 8]};
         ACC_HALF: rd_val = lane[1] ? {16'h0, rd_dw[31:16]} : {16'h0, rd_dw[15:0]};
         default:  rd_val = rd_dw;
      endcase
   end

endmodule

// File: rtl/cfgshim_shadow.sv
module cfgshim_shadow #(
   parameter int          SLOTS   = 10,
   parameter int          SLOT_W  = 4,
   parameter int          IO_SLOT = 3,
   parameter int          PF_SLOT = 5,
   parameter logic [31:0] IO_RST  = 32'h0,
   parameter logic [31:0] PF_RST  = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SLOT_W-1:0] wslot,
   input  logic [31:0]       wdata,
   input  logic [SLOT_W-1:0] rslot,
   output logic [31:0]       rdata
);

   if (SLOTS < 2 || (1 << SLOT_W) < SLOTS) begin : g_bad_slots
      $error("cfgshim_shadow: SLOT_W too narrow for SLOTS");
   end

   logic [SLOTS*32-1:0] flat;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam logic [31:0] RST = (s == IO_SLOT) ? IO_RST :
                                    (s == PF_SLOT) ? PF_RST : 32'h0;
      logic [31:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                           q <= RST;
         else if (we && wslot == SLOT_W'(s))   q <= wdata;
      end
      assign flat[s*32 +: 32] = q;
   end

   always_comb begin
      rdata = 32'h0;
      for (int s = 0; s < SLOTS; s++)
         if (rslot == SLOT_W'(s)) rdata = flat[s*32 +: 32];
   end

   assert_slot_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(wslot) < SLOTS));

endmodule

// File: rtl/cfgshim_patch.sv
module cfgshim_patch
   import cfgshim_pkg::*;
#(
   parameter int DW_W       = 10,
   parameter int HDR_DW     = 3,
   parameter int RC_DW      = 55,
   parameter int RV_EN_BIT  = 4,
   parameter int RV_CAP_BIT = 16
) (
   input  logic [31:0]     raw,
   input  logic [DW_W-1:0] dw,
   input  logic            rv_flag,
   output logic [31:0]     patched
);

   always_comb begin
      patched = raw;
      if (dw == DW_W'(HDR_DW))
         patched[HDR_TYPE_LSB +: 7] = HDR_TYPE_BRIDGE;
      if (dw == DW_W'(RC_DW)) begin
         patched[RV_EN_BIT]  = raw[RV_EN_BIT] | rv_flag;
         patched[RV_CAP_BIT] = 1'b1;
      end
   end

endmodule

// File: rtl/cfg_bridge_hdr_shim.sv
module cfg_bridge_hdr_shim
   import cfgshim_pkg::*;
#(
   parameter int OFFS_W     = 12,
   parameter int HDR_DW     = 3,
   parameter int SH_FIRST   = 4,
   parameter int SH_LAST    = 12,
   parameter int SH_EXTRA   = 14,
   parameter int BAR_A_DW   = 4,
   parameter int BAR_B_DW   = 5,
   parameter int SECBUS_DW  = 6,
   parameter int IO_DW      = 7,
   parameter int PF_DW      = 9,
   parameter int RC_DW      = 55,
   parameter int RV_EN_BIT  = 4,
   parameter int RV_CAP_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [OFFS_W-1:0] req_offset,
   input  logic [31:0]       req_wdata,
   output logic              done,
   output logic [31:0]       rdata,
   output logic              nat_rd_en,
   output logic              nat_wr_en,
   output logic [OFFS_W-1:0] nat_addr,
   output logic [31:0]       nat_wdata,
   input  logic [31:0]       nat_rdata,
   output logic [7:0]        sec_bus,
   output logic              retry_vis_en
);

   localparam int DW_W     = OFFS_W - 2;
   localparam int SH_SLOTS = SH_LAST - SH_FIRST + 2;
   localparam int SLOT_W   = $clog2(SH_SLOTS);

   if (OFFS_W < 8 || (RC_DW >> (DW_W)) != 0) begin : g_bad_offs
      $error("cfg_bridge_hdr_shim: OFFS_W too narrow for the header map");
   end
   if (SH_EXTRA <= SH_LAST || SH_FIRST > SH_LAST) begin : g_bad_window
      $error("cfg_bridge_hdr_shim: shadow window ordering is invalid");
   end
   if (RV_EN_BIT > 31 || RV_CAP_BIT > 31) begin : g_bad_bits
      $error("cfg_bridge_hdr_shim: retry-visibility bit out of range");
   end

   // request-cycle decode
   logic              accept;
   logic [DW_W-1:0]   req_dw;
   logic              req_hit;
   logic [SLOT_W-1:0] req_slot;
   logic [31:0]       sh_rdata;

   assign accept   = req_valid && !done;
   assign req_dw   = req_offset[OFFS_W-1:2];
   assign req_hit  = (req_dw >= DW_W'(SH_FIRST) && req_dw <= DW_W'(SH_LAST)) ||
                     (req_dw == DW_W'(SH_EXTRA));
   assign req_slot = (req_dw == DW_W'(SH_EXTRA)) ? SLOT_W'(SH_SLOTS - 1)
                                                 : SLOT_W'(req_dw - DW_W'(SH_FIRST));

   // captured access
   logic              wb_q, wr_q, hit_q;
   logic [1:0]        size_q;
   logic [OFFS_W-1:0] off_q;
   logic [31:0]       wdata_q, old_q;
   logic [SLOT_W-1:0] slot_q;
   logic [DW_W-1:0]   dw_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_q    <= 1'b0;
         wr_q    <= 1'b0;
         hit_q   <= 1'b0;
         size_q  <= 2'd0;
         off_q   <= '0;
         wdata_q <= 32'h0;
         old_q   <= 32'h0;
         slot_q  <= '0;
      end else begin
         wb_q <= accept;
         if (accept) begin
            wr_q    <= req_write;
            hit_q   <= req_hit;
            size_q  <= req_size;
            off_q   <= req_offset;
            wdata_q <= req_wdata;
            slot_q  <= req_slot;
            old_q   <= req_hit ? sh_rdata : nat_rdata;
         end
      end
   end

   assign dw_q = off_q[OFFS_W-1:2];
   assign done = wb_q;

   // lane merge and read extraction
   logic [31:0] merged, patched;

   cfgshim_lanes u_lanes (
      .base_dw   (old_q),
      .new_data  (wdata_q),
      .size      (size_q),
      .lane      (off_q[1:0]),
      .merged_dw (merged),
      .rd_dw     (patched),
      .rd_val    (rdata)
   );

   cfgshim_patch #(
      .DW_W       (DW_W),
      .HDR_DW     (HDR_DW),
      .RC_DW      (RC_DW),
      .RV_EN_BIT  (RV_EN_BIT),
      .RV_CAP_BIT (RV_CAP_BIT)
   ) u_patch (
      .raw     (old_q),
      .dw      (dw_q),
      .rv_flag (retry_vis_en),
      .patched (patched)
   );

   // shadow store, BAR dwords forced to zero
   logic        commit, bar_q, sh_we;
   logic [31:0] sh_wdata;

   assign commit   = wb_q && wr_q;
   assign bar_q    = (dw_q == DW_W'(BAR_A_DW)) || (dw_q == DW_W'(BAR_B_DW)) ||
                     (dw_q == DW_W'(SH_EXTRA));
   assign sh_we    = commit && hit_q;
   assign sh_wdata = bar_q ? 32'h0 : merged;

   cfgshim_shadow #(
      .SLOTS   (SH_SLOTS),
      .SLOT_W  (SLOT_W),
      .IO_SLOT (IO_DW - SH_FIRST),
      .PF_SLOT (PF_DW - SH_FIRST),
      .IO_RST  (IO_RANGE32_RST),
      .PF_RST  (PF_RANGE64_RST)
   ) u_shadow (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (sh_we),
      .wslot (slot_q),
      .wdata (sh_wdata),
      .rslot (req_slot),
      .rdata (sh_rdata)
   );

   // native port
   assign nat_rd_en = accept && !req_hit;
   assign nat_wr_en = commit && !hit_q;
   assign nat_addr  = wb_q ? {dw_q, 2'b00} : {req_dw, 2'b00};
   assign nat_wdata = merged;

   // snooped state for neighbours
   logic secbus_ld, rv_ld;

   assign secbus_ld = commit && (dw_q == DW_W'(SECBUS_DW)) &&
                      ((acc_size_e'(size_q) == ACC_WORD) || (acc_size_e'(size_q) == ACC_WIDE) ||
                       (acc_size_e'(size_q) == ACC_HALF && !off_q[1]) ||
                       (acc_size_e'(size_q) == ACC_BYTE && off_q[1:0] == 2'd1));
   assign rv_ld     = commit && (dw_q == DW_W'(RC_DW));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_bus      <= 8'h0;
         retry_vis_en <= 1'b0;
      end else begin
         if (secbus_ld) sec_bus      <= merged[15:8];
         if (rv_ld)     retry_vis_en <= merged[RV_EN_BIT];
      end
   end

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(req_valid));

   assert_rd_outside_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      nat_rd_en |-> !done);

   assert_wr_isolated_R1: assert property (@(posedge clk) disable iff (!rst_n)
      nat_wr_en |=> !nat_wr_en);

   assert_secbus_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sec_bus) |-> $past(done && wr_q && dw_q == DW_W'(SECBUS_DW)));

   assert_rv_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(retry_vis_en) |-> $past(done && wr_q && dw_q == DW_W'(RC_DW)));

endmodule

// File: tb/tb_cfg_bridge_hdr_shim.sv
`timescale 1ns/1ps
module tb_cfg_bridge_hdr_shim;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [11:0] req_offset = 12'h0;
   logic [31:0] req_wdata = 32'h0;
   logic        done, nat_rd_en, nat_wr_en, retry_vis_en;
   logic [31:0] rdata, nat_wdata, nat_rdata;
   logic [11:0] nat_addr;
   logic [7:0]  sec_bus;

   always #2.5 clk = ~clk;

   cfg_bridge_hdr_shim dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
      .req_offset(req_offset), .req_wdata(req_wdata),
      .done(done), .rdata(rdata),
      .nat_rd_en(nat_rd_en), .nat_wr_en(nat_wr_en), .nat_addr(nat_addr),
      .nat_wdata(nat_wdata), .nat_rdata(nat_rdata),
      .sec_bus(sec_bus), .retry_vis_en(retry_vis_en)
   );

   function automatic logic [31:0] nat_init(input int i);
      return 32'h1000_0000 + 32'(i) * 32'h0001_0203;
   endfunction

   // stand-in native register file, combinational read
   logic [31:0] nat_file [1024];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 1024; i++) nat_file[i] <= nat_init(i);
      end else if (nat_wr_en) begin
         nat_file[nat_addr[11:2]] <= nat_wdata;
      end
   end
   assign nat_rdata = nat_file[nat_addr[11:2]];

   // reference model state
   logic [31:0] m_nat [1024];
   logic [31:0] m_sh  [16];
   logic [7:0]  m_sec = 8'h0;
   logic        m_rv = 1'b0;
   logic        m_done = 1'b0;
   logic        mon_on = 1'b0;
   int          checks = 0;
   int          fails = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // per-clock comparison of the outputs with the model
   always @(negedge clk) begin
      if (rst_n && mon_on) begin
         chk("R10 done pulse", 32'(done), 32'(m_done));
         chk("R9 sec_bus", 32'(sec_bus), 32'(m_sec));
         chk("R4 retry_vis_en", 32'(retry_vis_en), 32'(m_rv));
      end
   end

   task automatic access(input logic wr, input logic [1:0] sz, input logic [11:0] off,
                         input logic [31:0] wd, input string tag, input bit stray);
      logic [9:0]  dw;
      bit          hit;
      int          sh;
      logic [31:0] old, mask, merged, patched, rexp;
      dw  = off[11:2];
      hit = (dw >= 4 && dw <= 12) || dw == 14;
      old = hit ? m_sh[dw[3:0]] : m_nat[dw];
      case (sz)
         2'd0:    begin sh = int'(off[1:0]);       mask = 32'hFF   << (8*sh); end
         2'd1:    begin sh = off[1] ? 2 : 0;       mask = 32'hFFFF << (8*sh); end
         default: begin sh = 0;                    mask = 32'hFFFF_FFFF;      end
      endcase
      merged  = (old & ~mask) | ((wd << (8*sh)) & mask);
      patched = old;
      if (dw == 3) patched[22:16] = 7'h01;
      if (dw == 55) begin
         patched[4]  = patched[4] | m_rv;
         patched[16] = 1'b1;
      end
      rexp = (patched & mask) >> (8*sh);

      @(negedge clk);
      req_valid  = 1'b1;
      req_write  = wr;
      req_size   = sz;
      req_offset = off;
      req_wdata  = wd;
      #1;
      chk({tag, " R1 native read strobe"}, 32'(nat_rd_en), 32'(!hit));
      @(posedge clk);
      m_done = 1'b1;
      #1 req_valid = 1'b0;
      @(negedge clk);
      if (!wr) chk({tag, " read data"}, rdata, rexp);
      chk({tag, " R1 native write strobe"}, 32'(nat_wr_en), 32'(wr && !hit));
      if (wr && !hit) chk({tag, " R7 native merged dword"}, nat_wdata, merged);
      if (stray) begin
         req_valid  = 1'b1;
         req_write  = 1'b1;
         req_size   = 2'd2;
         req_offset = 12'h020;
         req_wdata  = 32'hDEAD_BEEF;
      end
      @(posedge clk);
      m_done = 1'b0;
      if (stray) #1 req_valid = 1'b0;
      if (wr) begin
         if (hit) m_sh[dw[3:0]] = (dw == 4 || dw == 5 || dw == 14) ? 32'h0 : merged;
         else     m_nat[dw] = merged;
         if (dw == 55) m_rv = merged[4];
         if (dw == 6 && (sz >= 2'd2 || (sz == 2'd1 && !off[1]) ||
                         (sz == 2'd0 && off[1:0] == 2'd1)))
            m_sec = merged[15:8];
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      report();
      $finish;
   end

   initial begin
      for (int i = 0; i < 1024; i++) m_nat[i] = nat_init(i);
      for (int i = 0; i < 16; i++) m_sh[i] = 32'h0;
      m_sh[7] = 32'h0000_0101;
      m_sh[9] = 32'h0001_0001;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R10 reset done", 32'(done), 32'h0);
      chk("R9 reset sec_bus", 32'(sec_bus), 32'h0);
      chk("R4 reset flag", 32'(retry_vis_en), 32'h0);
      mon_on = 1'b1;

      // R6 reset shadow contents
      access(0, 2'd2, 12'h01C, 0, "R6 io range word", 0);
      access(0, 2'd2, 12'h024, 0, "R6 pref range word", 0);
      access(0, 2'd0, 12'h01D, 0, "R6 io limit byte", 0);
      access(0, 2'd1, 12'h026, 0, "R6 pref limit half", 0);
      access(0, 2'd2, 12'h030, 0, "R6 rom shadow zero", 0);

      // R8 native reads at every width and lane
      access(0, 2'd2, 12'h000, 0, "R8 word read", 0);
      access(0, 2'd0, 12'h002, 0, "R8 byte lane2", 0);
      access(0, 2'd0, 12'h007, 0, "R8 byte lane3", 0);
      access(0, 2'd1, 12'h006, 0, "R8 half upper", 0);
      access(0, 2'd1, 12'h008, 0, "R8 half lower", 0);

      // R3 header type patch
      access(0, 2'd2, 12'h00C, 0, "R3 header dword", 0);
      access(0, 2'd0, 12'h00E, 0, "R3 header byte", 0);
      access(1, 2'd0, 12'h00E, 32'hFF, "R3 header write", 0);
      access(0, 2'd2, 12'h00C, 0, "R3 header after write", 0);

      // R2 BAR dwords read zero after writes
      access(1, 2'd2, 12'h010, 32'hFFFF_FFFF, "R2 bar0 write", 0);
      access(0, 2'd2, 12'h010, 0, "R2 bar0 read", 0);
      access(1, 2'd0, 12'h015, 32'h5A, "R2 bar1 byte write", 0);
      access(0, 2'd2, 12'h014, 0, "R2 bar1 read", 0);
      access(1, 2'd1, 12'h03A, 32'h1234, "R2 rom half write", 0);
      access(0, 2'd2, 12'h038, 0, "R2 rom read", 0);

      // R7 shadow and native merges
      access(1, 2'd2, 12'h020, 32'hCAFE_F00D, "R7 shadow word", 0);
      access(1, 2'd0, 12'h022, 32'h77, "R7 shadow byte", 0);
      access(0, 2'd2, 12'h020, 0, "R7 shadow merged", 0);
      access(1, 2'd0, 12'h005, 32'hAB, "R7 native byte", 0);
      access(1, 2'd1, 12'h006, 32'h9876, "R7 native half", 0);
      access(0, 2'd2, 12'h004, 0, "R7 native merged", 0);
      access(1, 2'd2, 12'h041, 32'h0102_0304, "R7 word misaligned", 0);
      access(0, 2'd2, 12'h040, 0, "R7 word readback", 0);

      // R1 window edges
      access(1, 2'd2, 12'h034, 32'h1111_2222, "R1 edge 0x34 native", 0);
      access(0, 2'd2, 12'h034, 0, "R1 edge 0x34 read", 0);
      access(1, 2'd2, 12'h03C, 32'h3333_4444, "R1 edge 0x3C native", 0);
      access(1, 2'd2, 12'h02C, 32'h5555_6666, "R1 edge 0x2C shadow", 0);
      access(0, 2'd2, 12'h02C, 0, "R1 edge 0x2C read", 0);

      // R9 secondary bus snooping
      access(1, 2'd0, 12'h019, 32'h05, "R9 byte at 0x19", 0);
      access(1, 2'd0, 12'h018, 32'h77, "R9 byte at 0x18 no load", 0);
      access(1, 2'd1, 12'h018, 32'h0A02, "R9 half at 0x18", 0);
      access(1, 2'd1, 12'h01A, 32'hEEEE, "R9 half at 0x1A no load", 0);
      access(1, 2'd2, 12'h018, 32'h0012_3400, "R9 word", 0);
      access(0, 2'd2, 12'h018, 0, "R9 shadow readback", 0);

      // R4 / R5 retry visibility
      access(0, 2'd2, 12'h0DC, 0, "R5 root dword", 0);
      access(0, 2'd1, 12'h0DE, 0, "R5 capability half", 0);
      access(1, 2'd0, 12'h0DC, 32'h10, "R4 flag set", 0);
      access(0, 2'd2, 12'h0DC, 0, "R4 flag readback", 0);
      access(1, 2'd0, 12'h0DD, 32'h00, "R4 other byte keeps flag", 0);
      access(1, 2'd1, 12'h0DC, 32'h0000, "R4 flag clear", 0);
      access(0, 2'd0, 12'h0DC, 0, "R4 flag cleared read", 0);

      // R10 stray request in the done cycle is ignored
      access(0, 2'd2, 12'h004, 0, "R10 stray issuer", 1);
      access(0, 2'd2, 12'h020, 0, "R10 stray not written", 0);

      repeat (3) @(negedge clk);
      report();
      $finish;
   end

endmodule